// File: doc/BRIEF.md
# Nine-Bit Serial Transceiver with Address Filtering

This block is an asynchronous serial transmitter and receiver that works on eleven-bit frames. Each frame has a low start bit, eight data bits with the least significant bit first, a ninth bit chosen by software, and a high stop bit. The ninth bit can carry a parity value that software computes, or a marker that tells an address byte from a data byte on a shared multi-drop line. The line is high (mark) when idle.

A byte enters the transmitter through a valid/ready handshake. A transfer happens on a clock edge where both `tx_valid` and `tx_ready` are high. `tx_ready` stays low from that edge until the whole frame, stop bit included, has left the line. A byte offered while `tx_ready` is low is not taken, and the producer may drop `tx_valid` again without any effect. The ninth bit is taken from `tx_bit9` on the transfer edge.

The receiver samples the line on a tick that runs at sixteen times the bit rate. It keeps a received frame only if the previous byte has been read, which software shows by clearing the receive-done flag. When address filtering is on, the ninth bit must also be 1. Both done flags stay set until software writes a clear strobe. A single interrupt request combines the two flags under one enable.

Top module: `uart9_core`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1, and `tx_done`, `rx_done` and `irq` are 0. While `tx_ready` is 1, `txd` is 1.
- R2: An accepted byte is sent as start 0, data bits 0 to 7 in that order, the ninth bit, and stop 1. Each bit lasts 16 `baud_tick` pulses. The ninth bit is the value of `tx_bit9` on the transfer edge, and later changes to `tx_bit9` have no effect on it.
- R3: `tx_done` becomes 1 during the first cycles of the stop bit. It is still 0 in the middle of the ninth bit. `tx_ready` returns to 1 only after the stop bit has ended.
- R4: A `tx_valid` pulse while `tx_ready` is 0 changes neither the current frame nor the line after it: no second frame is sent.
- R5: A frame received while `rx_enable` is 1 and `rx_done` is 0, with `mp_mode` at 0, loads `rx_data` with the eight data bits and `rx_bit9` with the ninth bit, and sets `rx_done`.
- R6: If `rx_done` is 1 when a frame completes, the frame is dropped: `rx_data` and `rx_bit9` keep their values.
- R7: With `mp_mode` at 1, a frame whose ninth bit is 0 is dropped and `rx_done` stays 0. A frame whose ninth bit is 1 is accepted. With `mp_mode` at 0 the ninth bit does not affect acceptance.
- R8: While `rx_enable` is 0, no frame is received and `rx_done` stays 0.
- R9: A low pulse shorter than half a bit time does not start a frame. The receiver then accepts a proper frame that follows it.
- R10: The stop bit value is not checked. A frame whose stop bit is 0 is accepted like any other.
- R11: Each bit takes the majority of three samples near its centre. A disturbance that hits only one of these samples does not change the received value.
- R12: A done flag is cleared only by a one-cycle pulse on its clear input. It stays set for as long as no clear pulse arrives, and a clear pulse while the flag is 0 leaves it 0.
- R13: `irq` is 1 exactly when `irq_enable` is 1 and at least one of `tx_done` and `rx_done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_valid | input | 1 | A byte is offered for transmission |
| tx_ready | output | 1 | The transmitter is idle and takes a byte |
| tx_data | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit for the next frame to send |
| rx_enable | input | 1 | Allows reception |
| mp_mode | input | 1 | Keeps only frames whose ninth bit is 1 |
| irq_enable | input | 1 | Allows the interrupt request |
| tx_done_clr | input | 1 | Pulse that clears `tx_done` |
| rx_done_clr | input | 1 | Pulse that clears `rx_done` |
| tx_done | output | 1 | A frame has reached its stop bit |
| rx_done | output | 1 | A received frame is waiting |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
The bound checker looks at every cycle. It checks that the line is high while the transmitter is idle, and that `tx_done` rises only while the stop bit is on the line with the transmitter still busy. It checks that a held `rx_done` freezes the received byte and ninth bit, that acceptance respects the enable and address-filter settings, that flags fall only after a clear pulse, and that the interrupt needs a set flag. The bench scenarios cover the rest. They check the bit order and bit length on the line, the ignored write during a busy frame, short start glitches, single-sample disturbances, and stop bits of 0. None of these can be checked without building a whole frame.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

  // Majority vote of three line samples
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_bit9,
  output logic              ready,
  output logic              txd,
  output logic              stop_begin
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int CNT_W      = $clog2(OVS);
  localparam int IDX_W      = $clog2(FRAME_BITS);

  logic                  busy;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      sub;
  logic [IDX_W-1:0]      idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      shreg      <= '1;
      sub        <= '0;
      idx        <= '0;
      stop_begin <= 1'b0;
    end else begin
      stop_begin <= 1'b0;
      if (!busy) begin
        if (load_valid) begin
          busy  <= 1'b1;
          shreg <= {1'b1, load_bit9, load_data, 1'b0};
          sub   <= '0;
          idx   <= '0;
        end
      end else if (tick) begin
        if (sub == CNT_W'(OVS - 1)) begin
          sub <= '0;
          if (idx == IDX_W'(FRAME_BITS - 1)) begin
            busy  <= 1'b0;
            shreg <= '1;
          end else begin
            shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
            idx   <= idx + IDX_W'(1);
            if (idx == IDX_W'(FRAME_BITS - 2)) stop_begin <= 1'b1;
          end
        end else begin
          sub <= sub + CNT_W'(1);
        end
      end
    end
  end

  assign txd   = shreg[0];
  assign ready = !busy;

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              enable,
  output logic              frame_end,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_bit9
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int CNT_W      = $clog2(OVS);
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int MID        = OVS / 2;

  logic             s1, s2, prev;
  logic             active;
  logic [CNT_W-1:0] sub;
  logic [IDX_W-1:0] idx;
  logic             m0, m1;
  logic [DATA_W:0]  shreg;
  logic             vote;

  assign vote = maj3(m0, m1, s2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev      <= 1'b1;
      active    <= 1'b0;
      sub       <= '0;
      idx       <= '0;
      m0        <= 1'b1;
      m1        <= 1'b1;
      shreg     <= '0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (tick) prev <= s2;
      if (!enable) begin
        active <= 1'b0;
      end else if (!active) begin
        if (tick && prev && !s2) begin
          active <= 1'b1;
          sub    <= '0;
          idx    <= '0;
        end
      end else if (tick) begin
        if (sub == CNT_W'(OVS - 1)) begin
          sub <= '0;
          idx <= idx + IDX_W'(1);
        end else begin
          sub <= sub + CNT_W'(1);
        end
        if (sub == CNT_W'(MID - 1)) m0 <= s2;
        if (sub == CNT_W'(MID))     m1 <= s2;
        if (sub == CNT_W'(MID + 1)) begin
          if (idx == '0) begin
            if (vote) active <= 1'b0;
          end else if (idx == IDX_W'(FRAME_BITS - 1)) begin
            active    <= 1'b0;
            frame_end <= 1'b1;
          end else begin
            shreg <= {vote, shreg[DATA_W:1]};
          end
        end
      end
    end
  end

  assign frame_data = shreg[DATA_W-1:0];
  assign frame_bit9 = shreg[DATA_W];

endmodule

// File: rtl/uart9_flags.sv
module uart9_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_set,
  input  logic              frame_end,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_bit9,
  input  logic              mp_mode,
  input  logic              irq_enable,
  input  logic              tx_clr,
  input  logic              rx_clr,
  output logic              tx_done,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              irq
);
  logic accept;

  assign accept = frame_end && !rx_done && (!mp_mode || frame_bit9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      rx_data <= '0;
      rx_bit9 <= 1'b0;
    end else begin
      if (tx_set)      tx_done <= 1'b1;
      else if (tx_clr) tx_done <= 1'b0;
      if (accept) begin
        rx_done <= 1'b1;
        rx_data <= frame_data;
        rx_bit9 <= frame_bit9;
      end else if (rx_clr) begin
        rx_done <= 1'b0;
      end
    end
  end

  assign irq = irq_enable && (tx_done || rx_done);

endmodule

// File: rtl/uart9_core.sv
module uart9_core #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_bit9,
  input  logic              rx_enable,
  input  logic              mp_mode,
  input  logic              irq_enable,
  input  logic              tx_done_clr,
  input  logic              rx_done_clr,
  output logic              tx_done,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              irq,
  output logic              txd,
  input  logic              rxd
);
  logic              stop_begin;
  logic              frame_end;
  logic [DATA_W-1:0] frame_data;
  logic              frame_bit9;

  uart9_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .load_valid(tx_valid), .load_data(tx_data), .load_bit9(tx_bit9),
    .ready(tx_ready), .txd(txd), .stop_begin(stop_begin)
  );

  uart9_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd),
    .enable(rx_enable), .frame_end(frame_end),
    .frame_data(frame_data), .frame_bit9(frame_bit9)
  );

  uart9_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .tx_set(stop_begin),
    .frame_end(frame_end), .frame_data(frame_data), .frame_bit9(frame_bit9),
    .mp_mode(mp_mode), .irq_enable(irq_enable),
    .tx_clr(tx_done_clr), .rx_clr(rx_done_clr),
    .tx_done(tx_done), .rx_done(rx_done), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .irq(irq)
  );

endmodule

// File: rtl/uart9_chk.sv
module uart9_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_ready,
  input logic              txd,
  input logic              tx_done,
  input logic              rx_done,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              rx_enable,
  input logic              mp_mode,
  input logic              tx_done_clr,
  input logic              rx_done_clr,
  input logic              irq
);

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  p_done_at_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (txd && !tx_ready));

  p_hold_unread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_done) |-> ($stable(rx_data) && $stable(rx_bit9)));

  p_addr_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> (!$past(mp_mode) || rx_bit9));

  p_rx_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(rx_enable, 2));

  p_rx_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_done) |-> $past(rx_done_clr));

  p_tx_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_done) |-> $past(tx_done_clr));

  p_irq_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tx_done || rx_done));

endmodule

bind uart9_core uart9_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_uart9_core.sv
module test_uart9_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       tx_bit9 = 1'b0;
  logic       rx_enable = 1'b1;
  logic       mp_mode = 1'b0;
  logic       irq_enable = 1'b0;
  logic       tx_done_clr = 1'b0;
  logic       rx_done_clr = 1'b0;
  logic       tx_done, rx_done, rx_bit9, irq, txd;
  logic [7:0] rx_data;
  logic       rxd = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;
  int ph      = 0;
  bit finished = 0;

  // model of the receive-side registers
  bit       m_done = 0;
  bit [7:0] m_data = 0;
  bit       m_b9   = 0;

  uart9_core i_uart9_core (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_bit9(tx_bit9),
    .rx_enable(rx_enable), .mp_mode(mp_mode), .irq_enable(irq_enable),
    .tx_done_clr(tx_done_clr), .rx_done_clr(rx_done_clr),
    .tx_done(tx_done), .rx_done(rx_done), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .irq(irq), .txd(txd), .rxd(rxd)
  );

  always #10 clk = ~clk;

  // 16x tick: one pulse every 4 clocks
  always @(negedge clk) begin
    ph        <= (ph + 1) % 4;
    baud_tick <= (ph == 3);
  end

  function automatic bit frame_bit(input bit [7:0] d, input bit b9, input bit stop, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9) return b9;
    return stop;
  endfunction

  function automatic bit exp_accept(input bit en, input bit done, input bit mp, input bit b9);
    return en && !done && (!mp || b9);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic clr_rx();
    @(negedge clk) rx_done_clr = 1'b1;
    @(negedge clk) rx_done_clr = 1'b0;
    m_done = 0;
  endtask

  task automatic clr_tx();
    @(negedge clk) tx_done_clr = 1'b1;
    @(negedge clk) tx_done_clr = 1'b0;
  endtask

  // Drive one frame on rxd, aligned to a tick; glitch_bit inverts one sample window
  task automatic rx_frame(input bit [7:0] d, input bit b9, input bit stop,
                          input int glitch_bit, input bit short_start);
    bit v;
    forever begin
      @(negedge clk);
      if (ph == 3) break;
    end
    for (int c = 0; c < 704; c++) begin
      if (short_start) begin
        v = (c < 16) ? 1'b0 : 1'b1;
      end else begin
        v = frame_bit(d, b9, stop, c / 64);
        if ((c / 64) == glitch_bit && (c % 64) >= 38 && (c % 64) <= 41) v = ~v;
      end
      rxd = v;
      @(negedge clk);
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    if (!short_start && exp_accept(rx_enable, m_done, mp_mode, b9)) begin
      m_done = 1;
      m_data = d;
      m_b9   = b9;
    end
  endtask

  task automatic rx_compare(input string tag);
    chk({tag, " rx_done"}, rx_done, m_done);
    chk({tag, " rx_data"}, rx_data, m_data);
    chk({tag, " rx_bit9"}, rx_bit9, m_b9);
  endtask

  task automatic tx_frame(input bit [7:0] d, input bit b9, input bit poke);
    clr_tx();
    @(negedge clk);
    chk("R1 tx_ready before send", tx_ready, 1);
    tx_data = d; tx_bit9 = b9; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int c = 1; c <= 712; c++) begin
      if (c == 2) tx_bit9 = ~b9;
      if (poke && c == 100) begin tx_valid = 1'b1; tx_data = ~d; end
      if (poke && c == 101) tx_valid = 1'b0;
      if (c >= 32 && (c - 32) % 64 == 0 && (c - 32) / 64 <= 10) begin
        chk("R2 txd bit", txd, frame_bit(d, b9, 1'b1, (c - 32) / 64));
        if ((c - 32) / 64 == 9) chk("R3 tx_done still 0 in ninth bit", tx_done, 0);
        if ((c - 32) / 64 == 10) begin
          chk("R3 tx_done set in stop bit", tx_done, 1);
          chk("R3 tx_ready 0 during stop", tx_ready, 0);
        end
        if (poke) chk("R4 frame unchanged by busy write", txd, frame_bit(d, b9, 1'b1, (c - 32) / 64));
      end
      @(negedge clk);
    end
    chk("R3 tx_ready after stop", tx_ready, 1);
    if (poke) begin
      for (int c = 0; c < 128; c++) begin
        if (txd !== 1'b1) begin chk("R4 no second frame", txd, 1); break; end
        @(negedge clk);
      end
      chk("R4 line idle after busy write", txd, 1);
    end
  endtask

  initial begin
    bit [7:0] d;
    bit b9, mp, st, en;
    int gb;
    void'($urandom(32'h5eed_0909));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd idle", txd, 1);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 tx_done", tx_done, 0);
    chk("R1 rx_done", rx_done, 0);
    chk("R1 irq", irq, 0);

    // transmit: directed then random
    tx_frame(8'hA5, 1'b1, 1'b0);
    tx_frame(8'h3C, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) tx_frame(8'($urandom), 1'($urandom), 1'($urandom % 3 == 0));

    // R12: flag held without clear, clear acts
    repeat (200) @(negedge clk);
    chk("R12 tx_done held", tx_done, 1);
    clr_tx();
    @(negedge clk);
    chk("R12 tx_done cleared", tx_done, 0);
    clr_tx();
    @(negedge clk);
    chk("R12 clear on 0 keeps 0", tx_done, 0);

    // receive directed
    rx_frame(8'h5A, 1'b1, 1'b1, -1, 1'b0);
    rx_compare("R5 basic");
    rx_frame(8'hC3, 1'b0, 1'b1, -1, 1'b0);
    rx_compare("R6 unread drop");
    chk("R6 rx_data kept", rx_data, 8'h5A);
    repeat (300) @(negedge clk);
    chk("R12 rx_done held", rx_done, 1);
    clr_rx();
    @(negedge clk);
    chk("R12 rx_done cleared", rx_done, 0);

    mp_mode = 1'b1;
    rx_frame(8'h11, 1'b0, 1'b1, -1, 1'b0);
    rx_compare("R7 mp ninth 0");
    chk("R7 dropped", rx_done, 0);
    rx_frame(8'h22, 1'b1, 1'b1, -1, 1'b0);
    rx_compare("R7 mp ninth 1");
    chk("R7 accepted", rx_done, 1);
    clr_rx();
    mp_mode = 1'b0;
    rx_frame(8'h33, 1'b0, 1'b1, -1, 1'b0);
    rx_compare("R7 mp off ninth 0");
    clr_rx();

    rx_enable = 1'b0;
    rx_frame(8'h44, 1'b1, 1'b1, -1, 1'b0);
    chk("R8 disabled no frame", rx_done, 0);
    rx_enable = 1'b1;
    repeat (8) @(negedge clk);

    rx_frame(8'h00, 1'b0, 1'b1, -1, 1'b1);
    chk("R9 short start ignored", rx_done, 0);
    rx_frame(8'h96, 1'b1, 1'b1, -1, 1'b0);
    rx_compare("R9 frame after glitch");
    clr_rx();

    rx_frame(8'h7E, 1'b0, 1'b0, -1, 1'b0);
    rx_compare("R10 stop 0");
    clr_rx();

    rx_frame(8'hF0, 1'b1, 1'b1, 3, 1'b0);
    rx_compare("R11 one sample disturbed");
    clr_rx();
    rx_frame(8'h0F, 1'b0, 1'b1, 0, 1'b0);
    rx_compare("R11 start sample disturbed");

    // R13
    irq_enable = 1'b1;
    @(negedge clk);
    chk("R13 irq with rx_done", irq, 1);
    irq_enable = 1'b0;
    @(negedge clk);
    chk("R13 irq masked", irq, 0);
    irq_enable = 1'b1;
    clr_rx();
    @(negedge clk);
    chk("R13 irq no flags", irq, 0);

    // random receive mix
    for (int i = 0; i < 24; i++) begin
      d  = 8'($urandom);
      b9 = 1'($urandom);
      mp = 1'($urandom);
      st = ($urandom % 4) != 0;
      en = ($urandom % 8) != 0;
      gb = ($urandom % 2) ? int'($urandom % 11) : -1;
      if ($urandom % 3 != 0) clr_rx();
      mp_mode = mp;
      rx_enable = en;
      rx_frame(d, b9, st, gb, 1'b0);
      rx_compare("R5 random");
      chk("R13 irq random", irq, m_done);
    end
    finish_run();
  end

endmodule